// File: doc/BRIEF.md
# Link Rate Fallback Selector

After a link training attempt fails, a training sequencer must choose a reduced link configuration and try again. This block makes that choice. It takes the per-lane rate code and lane count that were just tried, along with the highest rate and lane count the sink advertises. It returns the next configuration to try, or a failure flag when nothing is left to step down to.

The step-down order is deliberately not monotonic. From the middle rate, only the rate drops. From the lowest rate, the lane count halves, and the rate climbs back to the middle rate if the sink can run faster. From the highest rate, lanes halve first. Once a single lane is reached at the highest rate, the rate drops to the middle one and the lane count goes back to the sink maximum.

The sequencer pulses `start` for one cycle with the operands on the inputs. Exactly one cycle later the block answers with a one-cycle `done` pulse. The result registers then hold their value until the next request.

Top module: `lfb_selector`

## Requirements
- R1: After reset, `done` and `fail` are 0 and `new_rate` and `new_lanes` are 0.
- R2: A request sampled with `start` high at a clock edge produces `done` high for exactly the following cycle. `done` is low in every cycle that does not follow a sampled `start`. Between requests, `new_rate`, `new_lanes` and `fail` hold the last result.
- R3: Rate codes are 8'h06 (1.62 Gbps), 8'h0A (2.7 Gbps) and 8'h14 (5.4 Gbps). From 8'h0A, the result is rate 8'h06 with the lane count unchanged.
- R4: From 8'h06 with `max_rate` numerically above 8'h06, the result is rate 8'h0A with the lane count halved (shift right by one).
- R5: From 8'h06 with `max_rate` not above 8'h06, the rate stays 8'h06 and the lane count is halved.
- R6: From 8'h14 with exactly one lane, the result is rate 8'h0A with the lane count set to `max_lanes`.
- R7: From 8'h14 with more than one lane, the rate stays 8'h14 and the lane count is halved.
- R8: Any rate code other than the three above gives `fail` = 1.
- R9: If the resulting lane count would be zero, `fail` = 1. This covers 8'h06 with one lane, 8'h14 with one lane and `max_lanes` = 0, and 8'h0A with zero lanes.
- R10: When `fail` is 1, `new_rate` and `new_lanes` equal the `cur_rate` and `cur_lanes` of that request.
- R11: Requests on consecutive cycles are each answered, in order, one cycle after their own `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| cur_rate | input | 8 | Rate code of the failed attempt |
| cur_lanes | input | LANE_W | Lane count of the failed attempt |
| max_rate | input | 8 | Highest rate code the sink supports |
| max_lanes | input | LANE_W | Highest lane count the sink supports |
| done | output | 1 | Result valid pulse |
| fail | output | 1 | No further configuration available |
| new_rate | output | 8 | Rate code to try next |
| new_lanes | output | LANE_W | Lane count to try next |

## Verification
Two things can happen in the same cycle: the result of one request is presented with `done`, and a fresh `start` arrives. The bench provokes this by holding `start` high on two consecutive edges with different operands, the first successful and the second failing. It then checks that each `done` cycle carries the result of its own request. In particular, the restore-on-failure values of the second request must not mix with the first answer.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] RATE_LOW  = 8'h06;
    localparam logic [CODE_W-1:0] RATE_MID  = 8'h0A;
    localparam logic [CODE_W-1:0] RATE_HIGH = 8'h14;

    typedef enum logic [1:0] {
        RC_LOW  = 2'd0,
        RC_MID  = 2'd1,
        RC_HIGH = 2'd2,
        RC_BAD  = 2'd3
    } rate_cls_e;
endpackage

// File: rtl/lfb_rate_class.sv
module lfb_rate_class
    import lfb_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output rate_cls_e         cls
);
    always_comb begin
        unique case (code)
            RATE_LOW:  cls = RC_LOW;
            RATE_MID:  cls = RC_MID;
            RATE_HIGH: cls = RC_HIGH;
            default:   cls = RC_BAD;
        endcase
    end
endmodule

// File: rtl/lfb_step.sv
module lfb_step
    import lfb_pkg::*;
#(
    parameter int LANE_W = 3
) (
    input  rate_cls_e         cls,
    input  logic [LANE_W-1:0] cur_lanes,
    input  logic [CODE_W-1:0] max_rate,
    input  logic [LANE_W-1:0] max_lanes,
    output logic [CODE_W-1:0] nxt_rate,
    output logic [LANE_W-1:0] nxt_lanes,
    output logic              nxt_fail
);
    localparam logic [LANE_W-1:0] ONE_LANE = LANE_W'(1);

    logic [LANE_W-1:0] halved;
    logic              bad_code;

    assign halved = cur_lanes >> 1;

    always_comb begin
        nxt_rate  = RATE_LOW;
        nxt_lanes = cur_lanes;
        bad_code  = 1'b0;
        unique case (cls)
            RC_MID: begin
                nxt_rate  = RATE_LOW;
                nxt_lanes = cur_lanes;
            end
            RC_LOW: begin
                nxt_rate  = (max_rate > RATE_LOW) ? RATE_MID : RATE_LOW;
                nxt_lanes = halved;
            end
            RC_HIGH: begin
                if (cur_lanes == ONE_LANE) begin
                    nxt_rate  = RATE_MID;
                    nxt_lanes = max_lanes;
                end else begin
                    nxt_rate  = RATE_HIGH;
                    nxt_lanes = halved;
                end
            end
            default: begin
                bad_code = 1'b1;
            end
        endcase
        nxt_fail = bad_code || (nxt_lanes == '0);
    end
endmodule

// File: rtl/lfb_selector.sv
module lfb_selector
    import lfb_pkg::*;
#(
    parameter int LANE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] cur_rate,
    input  logic [LANE_W-1:0] cur_lanes,
    input  logic [CODE_W-1:0] max_rate,
    input  logic [LANE_W-1:0] max_lanes,
    output logic              done,
    output logic              fail,
    output logic [CODE_W-1:0] new_rate,
    output logic [LANE_W-1:0] new_lanes
);
    typedef struct packed {
        logic              done;
        logic              fail;
        logic [CODE_W-1:0] rate;
        logic [LANE_W-1:0] lanes;
    } state_t;

    state_t r_d, r_q;

    rate_cls_e         cls;
    logic [CODE_W-1:0] step_rate;
    logic [LANE_W-1:0] step_lanes;
    logic              step_fail;

    lfb_rate_class i_class (
        .code (cur_rate),
        .cls  (cls)
    );

    lfb_step #(.LANE_W(LANE_W)) i_step (
        .cls       (cls),
        .cur_lanes (cur_lanes),
        .max_rate  (max_rate),
        .max_lanes (max_lanes),
        .nxt_rate  (step_rate),
        .nxt_lanes (step_lanes),
        .nxt_fail  (step_fail)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (start) begin
            r_d.done = 1'b1;
            r_d.fail = step_fail;
            if (step_fail) begin
                r_d.rate  = cur_rate;
                r_d.lanes = cur_lanes;
            end else begin
                r_d.rate  = step_rate;
                r_d.lanes = step_lanes;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign new_rate  = r_q.rate;
    assign new_lanes = r_q.lanes;
endmodule

// File: rtl/lfb_selector_chk.sv
module lfb_selector_chk
    import lfb_pkg::*;
#(
    parameter int LANE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CODE_W-1:0] cur_rate,
    input logic [LANE_W-1:0] cur_lanes,
    input logic [CODE_W-1:0] max_rate,
    input logic [LANE_W-1:0] max_lanes,
    input logic              done,
    input logic              fail,
    input logic [CODE_W-1:0] new_rate,
    input logic [LANE_W-1:0] new_lanes
);
    p_answer_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(new_rate) && $stable(new_lanes) && $stable(fail)));

    p_mid_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cur_rate == RATE_MID && cur_lanes != '0) |=>
        (!fail && new_rate == RATE_LOW && new_lanes == $past(cur_lanes)));

    p_high_multi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cur_rate == RATE_HIGH && cur_lanes > LANE_W'(1)) |=>
        (!fail && new_rate == RATE_HIGH));

    p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cur_rate != RATE_LOW && cur_rate != RATE_MID && cur_rate != RATE_HIGH)
        |=> fail);

    p_nonzero_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (new_lanes != '0));

    p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (new_rate == $past(cur_rate) && new_lanes == $past(cur_lanes)));

    logic unused_ok;
    assign unused_ok = ^{max_rate, max_lanes};
endmodule

bind lfb_selector lfb_selector_chk #(.LANE_W(LANE_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cur_rate  (cur_rate),
    .cur_lanes (cur_lanes),
    .max_rate  (max_rate),
    .max_lanes (max_lanes),
    .done      (done),
    .fail      (fail),
    .new_rate  (new_rate),
    .new_lanes (new_lanes)
);

// File: tb/test_lfb_selector.sv
module test_lfb_selector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cur_rate = '0;
    logic [2:0] cur_lanes = '0;
    logic [7:0] max_rate = '0;
    logic [2:0] max_lanes = '0;
    logic       done, fail;
    logic [7:0] new_rate;
    logic [2:0] new_lanes;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lfb_selector #(.LANE_W(3)) i_lfb_selector (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cur_rate(cur_rate), .cur_lanes(cur_lanes),
        .max_rate(max_rate), .max_lanes(max_lanes),
        .done(done), .fail(fail), .new_rate(new_rate), .new_lanes(new_lanes)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(int r, int l, int mr, int ml);
        start = 1'b1;
        cur_rate = 8'(r); cur_lanes = 3'(l);
        max_rate = 8'(mr); max_lanes = 3'(ml);
    endtask

    task automatic expect_result(string req, int er, int el, int ef);
        check({req, " done"}, int'(done), 1);
        check({req, " fail"}, int'(fail), ef);
        check({req, " rate"}, int'(new_rate), er);
        check({req, " lanes"}, int'(new_lanes), el);
    endtask

    task automatic one_req(string req, int r, int l, int mr, int ml,
                           int er, int el, int ef);
        @(negedge clk);
        drive(r, l, mr, ml);
        @(negedge clk);
        start = 1'b0;
        expect_result(req, er, el, ef);
        cur_rate = 8'h55; cur_lanes = 3'd7;
        @(negedge clk);
        check({req, " R2 done pulse ends"}, int'(done), 0);
        check({req, " R2 rate held"}, int'(new_rate), er);
        check({req, " R2 lanes held"}, int'(new_lanes), el);
    endtask

    task automatic test_reset();
        check("R1 done", int'(done), 0);
        check("R1 fail", int'(fail), 0);
        check("R1 rate", int'(new_rate), 0);
        check("R1 lanes", int'(new_lanes), 0);
    endtask

    task automatic test_mid();
        one_req("R3 mid 4 lanes", 'h0A, 4, 'h14, 4, 'h06, 4, 0);
        one_req("R3 mid 2 lanes", 'h0A, 2, 'h0A, 2, 'h06, 2, 0);
    endtask

    task automatic test_low();
        one_req("R4 low 4 max high", 'h06, 4, 'h14, 4, 'h0A, 2, 0);
        one_req("R4 low 2 max mid", 'h06, 2, 'h0A, 4, 'h0A, 1, 0);
        one_req("R5 low 4 max low", 'h06, 4, 'h06, 4, 'h06, 2, 0);
    endtask

    task automatic test_high();
        one_req("R6 high 1 max4", 'h14, 1, 'h14, 4, 'h0A, 4, 0);
        one_req("R6 high 1 max2", 'h14, 1, 'h14, 2, 'h0A, 2, 0);
        one_req("R7 high 4", 'h14, 4, 'h14, 4, 'h14, 2, 0);
        one_req("R7 high 2", 'h14, 2, 'h14, 4, 'h14, 1, 0);
    endtask

    task automatic test_fail();
        one_req("R8 R10 unknown code", 'h0C, 2, 'h14, 4, 'h0C, 2, 1);
        one_req("R9 R10 low single lane", 'h06, 1, 'h14, 4, 'h06, 1, 1);
        one_req("R9 R10 high 1 max0", 'h14, 1, 'h14, 0, 'h14, 1, 1);
        one_req("R9 R10 mid zero lanes", 'h0A, 0, 'h14, 4, 'h0A, 0, 1);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        drive('h14, 4, 'h14, 4);
        @(negedge clk);
        expect_result("R11 first", 'h14, 2, 0);
        drive('h06, 1, 'h0A, 2);
        @(negedge clk);
        start = 1'b0;
        expect_result("R11 second", 'h06, 1, 1);
        @(negedge clk);
        check("R11 quiet", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_mid();
        test_low();
        test_high();
        test_fail();
        test_back_to_back();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule